// File: doc/BRIEF.md
# Banked Clock Divider with Polarity Control

This block takes one input clock and fans it out to four banks of five outputs each. Every bank has its own rate select. The select picks either the input clock passed straight through or the input clock divided by two. A two-bit polarity code chooses which banks come out inverted. The code works like a thermometer: bank A is always inverted, and each step of the code adds the next bank in the order A, B, C, D.

A single active-low run/enable input does two jobs. While it is low, the internal divide-by-two flip-flops are held cleared and every output enable is driven off. Each output is carried as a data bit plus an enable bit, and the tri-state buffer is built from the enable outside the block. During that time the data lines rest at a known level: low for non-inverted banks and high for inverted banks. Rate and polarity are static configuration. They are meant to change only while the block is held in reset.

Top module: `banked_clkdiv`

## Requirements
- R1: The five outputs of one bank always carry the same data value.
- R2: A bank whose rate select is 1 follows the input clock level in every half period, inverted when its polarity flag is set.
- R3: A bank whose rate select is 0 changes level on every rising input edge while running, giving half the input frequency.
- R4: Banks at the full rate and at half rate may run at the same time, each with its own behaviour unaffected by the others.
- R5: All 20 output enables are 0 while the run/enable input is 0, and all are 1 while it is 1.
- R6: While held in reset (after at least one rising edge with the run/enable input low), a non-inverted bank's data is 0 and an inverted bank's data is 1, whatever the input clock level.
- R7: Bank index b (A=0, B=1, C=2, D=3) is inverted exactly when b is less than or equal to the unsigned value of the polarity code, so bank A is inverted for every code.
- R8: After reset is released, a half-rate bank keeps its reset level until the first rising input edge, changes on that edge, and then alternates on each later rising edge.
- R9: Output bits 5b to 5b+4 of the data and enable vectors belong to bank b, and rate-select bit b controls bank b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; also the source of the full-rate outputs |
| run_oe_n | input | 1 | Active-low combined divider reset and output enable, synchronous to clk_in |
| rate_sel | input | 4 | Per-bank rate select, bit b for bank b: 1 = input rate, 0 = half rate |
| pol_code | input | 2 | Thermometer polarity code selecting the inverted banks |
| q_data | output | 20 | Output data levels, five bits per bank |
| q_oe | output | 20 | Output enables, five bits per bank; 0 means high impedance |

## Verification
On every cycle, the assertions check that the outputs within each bank agree and that the enables follow the run/enable input. They also check that a half-rate bank alternates on each edge while running, and that a bank held in reset rests at the level its polarity code demands. Some behaviour only the bench's scenarios can show. This includes the exact phase of full-rate and half-rate banks against the input clock in both halves of the period, the first change on the first edge after release, and correct output across all 64 combinations of rate selects and polarity codes. The bench compares each of these against a behavioural edge-counting model at the middle of every high and low phase.

// File: rtl/banked_clkdiv_pkg.sv
// Package: shared constants and types for the banked clock divider.
// Assumes banks are indexed A=0 upward and all outputs in a bank are identical.
package banked_clkdiv_pkg;
    localparam int unsigned DEF_BANKS    = 4;
    localparam int unsigned DEF_PER_BANK = 5;
    localparam int unsigned DEF_POL_W    = 2;

    typedef enum logic {
        RATE_HALF = 1'b0,
        RATE_FULL = 1'b1
    } rate_e;
endpackage

// File: rtl/bank_polarity_decode.sv
// Module: turns the thermometer polarity code into one invert flag per bank.
// Bank b is inverted when b <= code, so bank 0 is inverted for any code.
// Assumes BANKS <= 2**POL_W so every bank can be reached by some code.
module bank_polarity_decode #(
    parameter int unsigned BANKS = 4,
    parameter int unsigned POL_W = 2
) (
    input  logic [POL_W-1:0] pol_code,
    output logic [BANKS-1:0] invert
);
    localparam int unsigned IDX_W = (POL_W > 1) ? POL_W + 1 : 2;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
        // Thermometer compare for this bank
        assign invert[b] = (BIDX <= IDX_W'(pol_code));
    end
endmodule

// File: rtl/bank_rate_gen.sv
// Module: produces one bank's level, either the input clock or a divide-by-two
// toggle, then applies the bank's invert flag. The toggle is cleared by the
// synchronous active-low run input; the full-rate path is gated low while
// the run input is low so that a bank rests at its polarity level.
// Assumes rate and invert are static while running.
module bank_rate_gen
    import banked_clkdiv_pkg::*;
(
    input  logic clk_in,
    input  logic run_n,
    input  logic rate,
    input  logic invert,
    output logic level
);
    logic half_q;
    logic raw;

    // Divide-by-two toggle with synchronous active-low clear
    always_ff @(posedge clk_in) begin
        if (!run_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

    // Pick the rate and apply polarity
    always_comb begin
        if (rate_e'(rate) == RATE_FULL) begin
            raw = clk_in & run_n;
        end else begin
            raw = half_q;
        end
        level = raw ^ invert;
    end
endmodule

// File: rtl/bank_fanout.sv
// Module: replicates one bank level and enable onto the bank's output slice.
// Assumes the enable is common to every output of the bank.
module bank_fanout #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             level,
    input  logic             enable,
    output logic [WIDTH-1:0] data_o,
    output logic [WIDTH-1:0] oe_o
);
    // Copy level and enable to every output of the bank
    always_comb begin
        data_o = {WIDTH{level}};
        oe_o   = {WIDTH{enable}};
    end
endmodule

// File: rtl/banked_clkdiv.sv
// Module: top of the banked clock divider. Decodes polarity, builds one rate
// generator and one fanout per bank, and packs bank b into bits
// [b*PER_BANK +: PER_BANK] of the output vectors.
// Assumes rate_sel and pol_code only change while run_oe_n is low.
module banked_clkdiv
    import banked_clkdiv_pkg::*;
#(
    parameter int unsigned BANKS    = DEF_BANKS,
    parameter int unsigned PER_BANK = DEF_PER_BANK,
    parameter int unsigned POL_W    = DEF_POL_W
) (
    input  logic                      clk_in,
    input  logic                      run_oe_n,
    input  logic [BANKS-1:0]          rate_sel,
    input  logic [POL_W-1:0]          pol_code,
    output logic [BANKS*PER_BANK-1:0] q_data,
    output logic [BANKS*PER_BANK-1:0] q_oe
);
    localparam int unsigned OUTS = BANKS * PER_BANK;

    logic [BANKS-1:0] bank_inv;
    logic [BANKS-1:0] bank_lvl;

    bank_polarity_decode #(
        .BANKS (BANKS),
        .POL_W (POL_W)
    ) u_pol (
        .pol_code (pol_code),
        .invert   (bank_inv)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_rate_gen u_rate (
            .clk_in (clk_in),
            .run_n  (run_oe_n),
            .rate   (rate_sel[b]),
            .invert (bank_inv[b]),
            .level  (bank_lvl[b])
        );

        bank_fanout #(
            .WIDTH (PER_BANK)
        ) u_fan (
            .level  (bank_lvl[b]),
            .enable (run_oe_n),
            .data_o (q_data[b*PER_BANK +: PER_BANK]),
            .oe_o   (q_oe[b*PER_BANK +: PER_BANK])
        );
    end

    if (OUTS == 0) begin : g_empty_guard
        initial $error("banked_clkdiv needs at least one output");
    end
endmodule

// File: rtl/banked_clkdiv_chk.sv
// Module: assertion checker bound to banked_clkdiv. Observes ports only.
module banked_clkdiv_chk #(
    parameter int unsigned BANKS    = 4,
    parameter int unsigned PER_BANK = 5,
    parameter int unsigned POL_W    = 2
) (
    input logic                      clk_in,
    input logic                      run_oe_n,
    input logic [BANKS-1:0]          rate_sel,
    input logic [POL_W-1:0]          pol_code,
    input logic [BANKS*PER_BANK-1:0] q_data,
    input logic [BANKS*PER_BANK-1:0] q_oe
);
    logic             held_q;
    logic [POL_W-1:0] pol_prev;

    // Remember whether the previous edge saw reset, and the previous code
    always_ff @(posedge clk_in) begin
        held_q   <= !run_oe_n;
        pol_prev <= pol_code;
    end

    // R5
    always_comb begin
        if (!run_oe_n) begin
            enables_off_chk: assert (q_oe == '0);
        end else begin
            enables_on_chk: assert (&q_oe);
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        // R1
        bank_uniform_chk: assert property (@(posedge clk_in) disable iff (!run_oe_n)
            (q_data[b*PER_BANK +: PER_BANK] == '0) ||
            (q_data[b*PER_BANK +: PER_BANK] == '1));

        // R3
        half_toggle_chk: assert property (@(posedge clk_in) disable iff (!run_oe_n)
            ($past(run_oe_n) && !rate_sel[b] && $stable(rate_sel) && $stable(pol_code))
            |-> (q_data[b*PER_BANK] != $past(q_data[b*PER_BANK])));

        // R6 R7
        always @(posedge clk_in) begin
            if (held_q && !run_oe_n && (pol_prev == pol_code)) begin
                rest_level_chk: assert (q_data[b*PER_BANK] == ((b <= int'(pol_code)) ? 1'b1 : 1'b0));
            end
        end
    end
endmodule

bind banked_clkdiv banked_clkdiv_chk #(
    .BANKS    (BANKS),
    .PER_BANK (PER_BANK),
    .POL_W    (POL_W)
) u_chk (
    .clk_in   (clk_in),
    .run_oe_n (run_oe_n),
    .rate_sel (rate_sel),
    .pol_code (pol_code),
    .q_data   (q_data),
    .q_oe     (q_oe)
);

// File: tb/banked_clkdiv_test.sv
// Bench: edge-counting reference model compared at mid-high and mid-low phase.
module banked_clkdiv_test;
    localparam int BANKS = 4;
    localparam int PER   = 5;
    localparam int OUTS  = BANKS * PER;

    logic            clk_in   = 1'b0;
    logic            run_oe_n = 1'b0;
    logic [3:0]      rate_sel = 4'hF;
    logic [1:0]      pol_code = 2'b11;
    logic [OUTS-1:0] q_data;
    logic [OUTS-1:0] q_oe;

    int vectors = 0;
    int errors  = 0;
    int edges   = 0;
    bit running = 1'b0;
    bit done    = 1'b0;

    banked_clkdiv uut (
        .clk_in   (clk_in),
        .run_oe_n (run_oe_n),
        .rate_sel (rate_sel),
        .pol_code (pol_code),
        .q_data   (q_data),
        .q_oe     (q_oe)
    );

    always #10 clk_in = ~clk_in;

    // Compare all 20 bits against the model for the given clock phase
    task automatic check_vec(input bit high_phase);
        logic [OUTS-1:0] exp_d;
        logic [OUTS-1:0] exp_e;
        for (int b = 0; b < BANKS; b++) begin
            bit inv = (b <= int'(pol_code));            // R7 thermometer
            bit raw;
            if (!running)          raw = 1'b0;          // R6 rest level
            else if (rate_sel[b])  raw = high_phase;    // R2 full rate
            else                   raw = edges[0];      // R3 R8 half rate
            for (int k = 0; k < PER; k++) begin         // R1 R9 mapping
                exp_d[b*PER + k] = raw ^ inv;
                exp_e[b*PER + k] = running;             // R5
            end
        end
        vectors++;
        if (q_data !== exp_d || q_oe !== exp_e) begin
            errors++;
            $display("FAIL R1 R2 R3 R5 R6 R7 R9 rate=%b pol=%b run=%0d high=%0d edges=%0d data=%h/%h oe=%h/%h (actual/expected)",
                     rate_sel, pol_code, running, high_phase, edges, q_data, exp_d, q_oe, exp_e);
        end
    endtask

    initial begin
        // Reset state: R5 R6
        repeat (2) @(posedge clk_in);
        #5 check_vec(1'b1);
        @(negedge clk_in); #5 check_vec(1'b0);
        // All 64 combinations; mixed rates cover R4
        for (int cfg = 0; cfg < 64; cfg++) begin
            @(negedge clk_in);
            #2;
            run_oe_n = 1'b0;
            running  = 1'b0;
            rate_sel = cfg[3:0];
            pol_code = cfg[5:4];
            @(posedge clk_in); #5 check_vec(1'b1);
            @(negedge clk_in); #5 check_vec(1'b0);
            @(posedge clk_in); #5 check_vec(1'b1);
            @(negedge clk_in);
            #2;
            run_oe_n = 1'b1;
            running  = 1'b1;
            edges    = 0;
            #3 check_vec(1'b0);                          // R8 before first edge
            for (int c = 0; c < 6; c++) begin
                @(posedge clk_in);
                edges++;
                #5 check_vec(1'b1);
                @(negedge clk_in); #5 check_vec(1'b0);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule